// File: doc/BRIEF.md
# SPI Target Pause Gate

This block sits between the pins of an SPI target and its serial shift register. A bus controller that shares the serial clock with other targets can pause a transfer midway by pulling an active-low pause pin. While paused, the shifter sees no clock edges and a frozen serial input, and the serial output is released to high impedance. When the pause ends, the shifter continues with the bit at which it stopped. The transfer is not restarted.

Everything runs in one system clock domain. The four pins (select, serial clock, serial input, pause) pass through a synchroniser of `SYNC_STAGES` flops. The serial clock is then turned into one-cycle rising-edge and falling-edge enables for the shifter. The pause state is a registered flag. It can only be entered or left while the synchronised serial clock is low. A pause request made while the clock is high waits for the clock to fall. A release made while the clock is high is ignored. Raising the select pin aborts the transfer and clears any pause.

Top module: `spi_hold_gate`

## Requirements
- R1: With select low and the serial clock low, a low level on `hold_n_pin` sets `paused` to 1.
- R2: A pause ends only on a low-to-high transition of `hold_n_pin` that is seen while the serial clock is low. `paused` then returns to 0.
- R3: While `paused` is 1, `sck_rise_en` and `sck_fall_en` stay 0 and `si_gated` keeps its value. Edges and serial-input changes during a pause are lost, not queued.
- R4: `sdo_oe` is 1 only when select is low, `hold_n_pin` is high, `paused` is 0 and `sdo_en` is 1. A low `hold_n_pin` forces it to 0 even before the pause takes effect. `sdo_pin` is the registered copy of `sdo_data`.
- R5: A low `hold_n_pin` that arrives while the serial clock is high does not pause at once. The pause begins when the clock falls. The falling edge that ends that phase is still passed on as one `sck_fall_en` pulse.
- R6: If `hold_n_pin` rises while the serial clock is high, the block stays paused, even after the clock later falls. A new low-then-high cycle of `hold_n_pin` with the clock low is needed to resume.
- R7: A high `cs_n_pin` clears the pause, keeps both edge enables at 0 and forces `sdo_oe` to 0. While select is high, no pause can be entered.
- R8: A change on any pin shows at the outputs exactly `SYNC_STAGES`+1 system clock cycles later.
- R9: Synchronous active-high `rst` sets `paused`, `sck_rise_en`, `sck_fall_en`, `si_gated`, `sdo_pin` and `sdo_oe` to 0.
- R10: While running, each rise of the serial clock gives exactly one `sck_rise_en` pulse and each fall gives exactly one `sck_fall_en` pulse. After a resume, counting continues with no pulse added or lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_pin | input | 1 | Target select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| sdo_data | input | 1 | Output bit from the shifter |
| sdo_en | input | 1 | Output enable from the shifter |
| sck_rise_en | output | 1 | One-cycle enable per accepted serial clock rise |
| sck_fall_en | output | 1 | One-cycle enable per accepted serial clock fall |
| si_gated | output | 1 | Serial input toward the shifter, frozen while paused |
| sdo_pin | output | 1 | Serial output data to the pin driver |
| sdo_oe | output | 1 | Serial output drive enable |
| paused | output | 1 | Pause flag |

## Verification
Some rules are checked by assertions on every cycle:
- the pause begins only after a cycle with the serial clock low;
- it ends only through select or a pause release seen while the clock is low;
- edge enables stay 0 and the gated input holds its value during a pause;
- the output enable drops whenever the synchronised pause pin is low or select is high.

Other behaviour can only be shown by the bench's scenarios:
- the deferred entry that still passes the falling edge which ends the high phase;
- the refusal to resume after a release while the clock is high, even once the clock falls;
- the exact pin-to-output latency;
- that no edge is lost or duplicated across a pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int NSIG    = 4;
  localparam int IDX_CS  = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_SI  = 2;
  localparam int IDX_HLD = 3;
  // select and pause pins idle high, clock and data idle low
  localparam logic [NSIG-1:0] PIN_IDLE = 4'b1001;

  typedef enum logic {PH_RUN = 1'b0, PH_HALT = 1'b1} pause_st_t;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic hold_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic hold_rise
);
  logic sck_prev;
  logic hold_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev  <= 1'b0;
      hold_prev <= 1'b1;
    end else begin
      sck_prev  <= sck_s;
      hold_prev <= hold_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_prev;
  assign sck_fall  = ~sck_s & sck_prev;
  assign hold_rise = hold_s & ~hold_prev;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  input  logic hold_rise,
  output logic paused_q,
  output logic paused_nxt
);
  pause_st_t st, st_n;

  always_comb begin
    st_n = st;
    if (cs_s) begin
      st_n = PH_RUN;
    end else if (st == PH_RUN) begin
      if (!hold_s && !sck_s) st_n = PH_HALT;
    end else begin
      if (hold_rise && !sck_s) st_n = PH_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= PH_RUN;
    else     st <= st_n;
  end

  assign paused_q   = (st == PH_HALT);
  assign paused_nxt = (st_n == PH_HALT);

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !paused_q); // R7
  AST_ENTRY_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(paused_q) |-> !$past(sck_s) && !$past(hold_s)); // R1
  AST_EXIT_RULE: assert property (@(posedge clk) disable iff (rst)
    $fell(paused_q) |-> $past(rst) || $past(cs_s) ||
                        ($past(hold_rise) && !$past(sck_s))); // R2
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  input  logic hold_n_pin,
  input  logic sdo_data,
  input  logic sdo_en,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic si_gated,
  output logic sdo_pin,
  output logic sdo_oe,
  output logic paused
);
  logic [NSIG-1:0] pins_raw, pins_s;
  logic cs_s, sck_s, si_s, hold_s;
  logic sck_rise, sck_fall, hold_rise;
  logic paused_nxt;

  assign pins_raw[IDX_CS]  = cs_n_pin;
  assign pins_raw[IDX_SCK] = sck_pin;
  assign pins_raw[IDX_SI]  = si_pin;
  assign pins_raw[IDX_HLD] = hold_n_pin;

  spi_hold_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  assign cs_s   = pins_s[IDX_CS];
  assign sck_s  = pins_s[IDX_SCK];
  assign si_s   = pins_s[IDX_SI];
  assign hold_s = pins_s[IDX_HLD];

  spi_hold_edge i_edge (
    .clk(clk), .rst(rst), .sck_s(sck_s), .hold_s(hold_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .hold_rise(hold_rise)
  );

  spi_hold_fsm i_fsm (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
    .hold_rise(hold_rise), .paused_q(paused), .paused_nxt(paused_nxt)
  );

  // edges are gated by the pause flag as it stood before this cycle, so the
  // fall that completes a deferred entry still reaches the shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_rise_en <= 1'b0;
      sck_fall_en <= 1'b0;
      si_gated    <= 1'b0;
      sdo_pin     <= 1'b0;
      sdo_oe      <= 1'b0;
    end else begin
      sck_rise_en <= sck_rise & ~paused & ~cs_s;
      sck_fall_en <= sck_fall & ~paused & ~cs_s;
      if (!paused) si_gated <= si_s;
      sdo_pin     <= sdo_data;
      sdo_oe      <= sdo_en & ~cs_s & hold_s & ~paused_nxt;
    end
  end

  AST_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    paused |=> !sck_rise_en && !sck_fall_en); // R3
  AST_SI_FROZEN: assert property (@(posedge clk) disable iff (rst)
    paused |=> $stable(si_gated)); // R3
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !sdo_oe); // R4
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe && !sck_rise_en && !sck_fall_en); // R7
endmodule

// File: tb/test_spi_hold_gate.sv
module test_spi_hold_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 23;

  // pins: cs sck si hold data en | expected: paused oe so si rise fall
  localparam logic [11:0] TBL [NROW] = '{
    12'b000111_011000, // 0  select, idle
    12'b011111_011110, // 1  R10 rise
    12'b001111_011101, // 2  R10 fall
    12'b001011_101100, // 3  R1 immediate entry, R4
    12'b010011_101100, // 4  R3 edge and si ignored
    12'b000011_101100, // 5  R3 fall ignored
    12'b000111_011000, // 6  R2 resume
    12'b010111_011010, // 7  R10 rise after resume
    12'b010011_001000, // 8  R5 deferred, R4 oe low at once
    12'b000011_101001, // 9  R5 entry on fall, fall passed
    12'b010011_101000, // 10 R3
    12'b010111_101000, // 11 R6 release with clock high
    12'b000111_101000, // 12 R6 still paused
    12'b000011_101000, // 13 R6 new low
    12'b000111_011000, // 14 R2 resume
    12'b001101_010100, // 15 R4 data follows
    12'b011101_010110, // 16 R10
    12'b001101_010101, // 17 R10
    12'b001001_100100, // 18 R1
    12'b100001_000000, // 19 R7 abort
    12'b110001_000000, // 20 R7 no entry, no edge
    12'b100101_000000, // 21 R7
    12'b000100_000000  // 22 R4 enable low
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1;
  logic sdo_data = 1'b0, sdo_en = 1'b0;
  logic sck_rise_en, sck_fall_en, si_gated, sdo_pin, sdo_oe, paused;
  int n_chk = 0, n_bad = 0;
  int rc = 0, fc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_gate i_spi_hold_gate (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin), .si_pin(si_pin),
    .hold_n_pin(hold_n_pin), .sdo_data(sdo_data), .sdo_en(sdo_en),
    .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en), .si_gated(si_gated),
    .sdo_pin(sdo_pin), .sdo_oe(sdo_oe), .paused(paused)
  );

  always @(negedge clk) begin
    if (sck_rise_en) rc++;
    if (sck_fall_en) fc++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R9 reset state
    chk("R9", "paused", paused, 0);
    chk("R9", "oe", sdo_oe, 0);
    chk("R9", "rise", sck_rise_en, 0);
    chk("R9", "fall", sck_fall_en, 0);
    chk("R9", "si", si_gated, 0);
    chk("R9", "so", sdo_pin, 0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      logic [11:0] v;
      int r0, f0;
      string tag;
      v = TBL[i];
      tag = $sformatf("row%0d", i);
      @(negedge clk);
      {cs_n_pin, sck_pin, si_pin, hold_n_pin, sdo_data, sdo_en} = v[11:6];
      #1;
      r0 = rc; f0 = fc;
      repeat (6) @(negedge clk);
      #1;
      chk(tag, "paused", paused, v[5]);
      chk(tag, "oe", sdo_oe, v[4]);
      chk(tag, "so", sdo_pin, v[3]);
      chk(tag, "si", si_gated, v[2]);
      chk(tag, "rise", rc - r0, v[1]);
      chk(tag, "fall", fc - f0, v[0]);
    end

    // R8 latency: select low, enable high, oe is 1; drop pause pin
    @(negedge clk);
    {cs_n_pin, sck_pin, si_pin, hold_n_pin, sdo_data, sdo_en} = 6'b000111;
    repeat (6) @(negedge clk);
    hold_n_pin = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R8", "oe before latency", sdo_oe, 1);
    chk("R8", "paused before latency", paused, 0);
    @(negedge clk);
    #1;
    chk("R8", "oe at latency", sdo_oe, 0);
    chk("R8", "paused at latency", paused, 1);

    // R9 reset during a pause
    @(negedge clk);
    rst = 1'b1;
    cs_n_pin = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "paused after mid reset", paused, 0);
    chk("R9", "oe after mid reset", sdo_oe, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R7", "paused with select high", paused, 0);

    done = 1;
    summary();
  end
endmodule